// File: doc/BRIEF.md
# I/O Translation Unit Control and Status Registers

This block is the register file that sits beside an I/O address translation unit. Software reaches it over a plain word-wide bus with read strobe, write strobe, byte address, write data and read data. It holds these registers: the translation control word, the page-table base, two flush words, a fault status word and a fault address word, an arbiter enable word, a configuration word for each of four bus slots, an arbitration enable word and an identification word. Each write passes through a mask that belongs to its register, and some registers then have fixed bits forced on.

When software writes the control word, the block decodes the three-bit range field into the lowest address of the translation window. The window always ends at the top of the 32-bit space. The block exports the table base, the window start and the enable bit to the translation unit. The translation unit reports a failed lookup on a capture port. The block then records the status and the page address and raises a level interrupt. Software lowers the interrupt by reading or writing either fault register.

Top module: `ioxlat_csr`

## Requirements
- R1: After reset: control reads {IMPL_VER,24'h0}. Arbitration enable (0x2000) reads 0x00000008. Fault status (0x1000) reads 0x00800000. Arbiter enable (0x1008) reads 0x00000003. Mask ID (0x3018) reads 0x23000000. Every other register reads zero. The interrupt, window start, enable export and base export are all zero.
- R2: A write to control (0x0000) keeps only the data bits under 0x0000001D, with the range field in [4:2] and enable in bit 0. The register then reads back those bits ORed with {IMPL_VER,24'h0}. The xlat_en output follows bit 0.
- R3: A control write with range field n (0..7) sets win_start to 0xFFFFFFFF shifted left by 24+n. That gives 0xFF000000 for n=0 and 0x80000000 for n=7. win_start changes only on control writes.
- R4: The base register (0x0004) keeps the bits under 0x07FFFC00 and drives tbl_base. The flush registers (0x0014, 0x0018) keep all 32 bits.
- R5: A write to arbiter enable (0x1008) keeps the bits under 0x801F000F and always sets bit 0.
- R6: A write to fault status keeps the bits under 0xFF0FFFFF and always sets bit 23. Fault address (0x1004) keeps all 32 bits.
- R7: A write to a slot config register (0x1010, 0x1014, 0x1018, 0x101C) keeps the bits under 0x00010003. A write to arbitration enable keeps the bits under 0x001F0000 and sets 0x00000008.
- R8: A write to mask ID ORs the data under 0x00FFFFFF into the current value. Bits already set are never cleared.
- R9: A pulse on flt_valid loads fault status with 0xC0820000, plus 0x00040000 when flt_is_read is 1. It loads fault address with flt_page and raises irq after that clock edge. In a cycle with both a capture and a bus write to a fault register, the capture wins.
- R10: A bus read or write of fault status or fault address without a capture in the same cycle lowers irq at that edge. Any other access leaves irq unchanged.
- R11: An access to an offset not listed above, including an offset that is not word aligned, reads zero. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 14 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |
| flt_valid | input | 1 | Fault capture strobe from the translation unit |
| flt_is_read | input | 1 | The faulting access was a read |
| flt_page | input | 32 | Page address of the faulting access |
| irq | output | 1 | Level fault interrupt |
| tbl_base | output | 32 | Page-table base register value |
| win_start | output | 32 | Lowest address of the translation window |
| xlat_en | output | 1 | Translation enable bit |

## Verification
The usual fault in this block is a wrong mask or a missing forced bit. It appears on bus_rdata during the first read after the offending write, one cycle later. A bad range decode appears on win_start right after the control write edge. A wrong interrupt state appears on irq one edge after the capture or the fault-register access. The bench therefore tests each register with all-ones and all-zeros data, walks every range value, and checks irq around every action that is meant to set it, clear it or leave it alone.

// File: rtl/ioxc_pkg.sv
package ioxc_pkg;

    localparam int DW        = 32;
    localparam int AW        = 14;
    localparam int NUM_SLOTS = 4;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);

    typedef logic [DW-1:0] word_t;

    localparam logic [AW-1:0] OFS_CTRL   = 14'h0000;
    localparam logic [AW-1:0] OFS_BASE   = 14'h0004;
    localparam logic [AW-1:0] OFS_TFLUSH = 14'h0014;
    localparam logic [AW-1:0] OFS_PFLUSH = 14'h0018;
    localparam logic [AW-1:0] OFS_FSTAT  = 14'h1000;
    localparam logic [AW-1:0] OFS_FADDR  = 14'h1004;
    localparam logic [AW-1:0] OFS_ARBMSK = 14'h1008;
    localparam logic [AW-1:0] OFS_SLOT0  = 14'h1010;
    localparam logic [AW-1:0] OFS_ARBEN  = 14'h2000;
    localparam logic [AW-1:0] OFS_IDENT  = 14'h3018;

    localparam word_t MSK_CTRL   = 32'h0000_001D;
    localparam word_t MSK_BASE   = 32'h07FF_FC00;
    localparam word_t MSK_ARBMSK = 32'h801F_000F;
    localparam word_t SET_ARBMSK = 32'h0000_0001;
    localparam word_t MSK_FSTAT  = 32'hFF0F_FFFF;
    localparam word_t SET_FSTAT  = 32'h0080_0000;
    localparam word_t MSK_SLOT   = 32'h0001_0003;
    localparam word_t MSK_ARBEN  = 32'h001F_0000;
    localparam word_t SET_ARBEN  = 32'h0000_0008;
    localparam word_t MSK_IDENT  = 32'h00FF_FFFF;

    localparam word_t RST_ARBEN  = 32'h0000_0008;
    localparam word_t RST_FSTAT  = 32'h0080_0000;
    localparam word_t RST_ARBMSK = 32'h0000_0003;
    localparam word_t RST_IDENT  = 32'h2300_0000;

    // Capture status: error summary, late error, reserved one, address valid
    localparam word_t FLT_STATUS = 32'hC082_0000;
    localparam word_t FLT_RDBIT  = 32'h0004_0000;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_BASE,
        SEL_TFLUSH,
        SEL_PFLUSH,
        SEL_FSTAT,
        SEL_FADDR,
        SEL_ARBMSK,
        SEL_SLOT,
        SEL_ARBEN,
        SEL_IDENT
    } sel_e;

    typedef struct packed {
        sel_e              sel;
        logic [SLOT_W-1:0] slot;
    } decode_t;

    function automatic word_t win_from_range(input logic [2:0] rng);
        return 32'hFFFF_FFFF << (5'd24 + {2'b00, rng});
    endfunction

    function automatic logic [AW-1:0] slot_offset(input int idx);
        return OFS_SLOT0 + AW'(4 * idx);
    endfunction

endpackage

// File: rtl/ioxc_decode.sv
module ioxc_decode
    import ioxc_pkg::*;
(
    input  logic [AW-1:0] addr,
    output decode_t       dec
);
    always_comb begin
        dec.sel  = SEL_NONE;
        dec.slot = '0;
        unique case (addr)
            OFS_CTRL:   dec.sel = SEL_CTRL;
            OFS_BASE:   dec.sel = SEL_BASE;
            OFS_TFLUSH: dec.sel = SEL_TFLUSH;
            OFS_PFLUSH: dec.sel = SEL_PFLUSH;
            OFS_FSTAT:  dec.sel = SEL_FSTAT;
            OFS_FADDR:  dec.sel = SEL_FADDR;
            OFS_ARBMSK: dec.sel = SEL_ARBMSK;
            OFS_ARBEN:  dec.sel = SEL_ARBEN;
            OFS_IDENT:  dec.sel = SEL_IDENT;
            default:    dec.sel = SEL_NONE;
        endcase
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (addr == slot_offset(i)) begin
                dec.sel  = SEL_SLOT;
                dec.slot = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/ioxc_irq.sv
module ioxc_irq (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_evt,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)          irq <= 1'b0;
        else if (set_evt) irq <= 1'b1;
        else if (clr_evt) irq <= 1'b0;
    end

    assert_irq_raise_R9: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> irq);
    assert_irq_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (clr_evt && !set_evt) |=> !irq);
    assert_irq_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!clr_evt && !set_evt) |=> $stable(irq));
endmodule

// File: rtl/ioxc_store.sv
module ioxc_store
    import ioxc_pkg::*;
#(
    parameter logic [7:0] IMPL_VER = 8'h00
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  decode_t dec,
    input  word_t   wdata,
    input  logic    flt_valid,
    input  logic    flt_is_read,
    input  word_t   flt_page,
    output word_t   rd_word,
    output word_t   tbl_base,
    output word_t   win_start,
    output logic    xlat_en
);
    localparam word_t VER_WORD = {IMPL_VER, 24'h0};

    word_t ctrl_q, base_q, tfl_q, pfl_q, fstat_q, faddr_q;
    word_t arbmsk_q, arben_q, ident_q, win_q;
    word_t slot_q [NUM_SLOTS];

    logic wr_ctrl, wr_flt_stat, wr_flt_addr;
    assign wr_ctrl     = wr_en && (dec.sel == SEL_CTRL);
    assign wr_flt_stat = wr_en && (dec.sel == SEL_FSTAT);
    assign wr_flt_addr = wr_en && (dec.sel == SEL_FADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= VER_WORD;
            win_q    <= '0;
            base_q   <= '0;
            tfl_q    <= '0;
            pfl_q    <= '0;
            arbmsk_q <= RST_ARBMSK;
            arben_q  <= RST_ARBEN;
            ident_q  <= RST_IDENT;
        end else if (wr_en) begin
            case (dec.sel)
                SEL_CTRL: begin
                    ctrl_q <= (wdata & MSK_CTRL) | VER_WORD;
                    win_q  <= win_from_range(wdata[4:2]);
                end
                SEL_BASE:   base_q   <= wdata & MSK_BASE;
                SEL_TFLUSH: tfl_q    <= wdata;
                SEL_PFLUSH: pfl_q    <= wdata;
                SEL_ARBMSK: arbmsk_q <= (wdata & MSK_ARBMSK) | SET_ARBMSK;
                SEL_ARBEN:  arben_q  <= (wdata & MSK_ARBEN) | SET_ARBEN;
                SEL_IDENT:  ident_q  <= ident_q | (wdata & MSK_IDENT);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (rst)
                slot_q[i] <= '0;
            else if (wr_en && dec.sel == SEL_SLOT && dec.slot == SLOT_W'(i))
                slot_q[i] <= wdata & MSK_SLOT;
        end
    end

    // Capture from the translation unit outranks a bus write
    always_ff @(posedge clk) begin
        if (rst) begin
            fstat_q <= RST_FSTAT;
            faddr_q <= '0;
        end else if (flt_valid) begin
            fstat_q <= FLT_STATUS | (flt_is_read ? FLT_RDBIT : '0);
            faddr_q <= flt_page;
        end else begin
            if (wr_flt_stat) fstat_q <= (wdata & MSK_FSTAT) | SET_FSTAT;
            if (wr_flt_addr) faddr_q <= wdata;
        end
    end

    always_comb begin
        case (dec.sel)
            SEL_CTRL:   rd_word = ctrl_q;
            SEL_BASE:   rd_word = base_q;
            SEL_TFLUSH: rd_word = tfl_q;
            SEL_PFLUSH: rd_word = pfl_q;
            SEL_FSTAT:  rd_word = fstat_q;
            SEL_FADDR:  rd_word = faddr_q;
            SEL_ARBMSK: rd_word = arbmsk_q;
            SEL_SLOT:   rd_word = slot_q[dec.slot];
            SEL_ARBEN:  rd_word = arben_q;
            SEL_IDENT:  rd_word = ident_q;
            default:    rd_word = '0;
        endcase
    end

    assign tbl_base  = base_q;
    assign win_start = win_q;
    assign xlat_en   = ctrl_q[0];

    assert_ident_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((ident_q & $past(ident_q)) == $past(ident_q)));
    assert_capture_status_R9: assert property (@(posedge clk) disable iff (rst)
        flt_valid |=> ((fstat_q & FLT_STATUS) == FLT_STATUS) && (faddr_q == $past(flt_page)));
    assert_win_top_R3: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> (win_q[31] && win_q[23:0] == 24'h0));
    assert_win_stable_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> $stable(win_q));
    assert_fstat_resv_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_flt_stat || flt_valid) |=> fstat_q[23]);
    assert_arbmsk_bit0_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.sel == SEL_ARBMSK) |=> arbmsk_q[0]);
endmodule

// File: rtl/ioxlat_csr.sv
module ioxlat_csr
    import ioxc_pkg::*;
#(
    parameter logic [7:0] IMPL_VER = 8'h00
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [13:0]   bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic          flt_valid,
    input  logic          flt_is_read,
    input  logic [31:0]   flt_page,
    output logic          irq,
    output logic [31:0]   tbl_base,
    output logic [31:0]   win_start,
    output logic          xlat_en
);
    decode_t dec;
    logic    touch_fault;

    ioxc_decode u_decode (
        .addr (bus_addr),
        .dec  (dec)
    );

    ioxc_store #(.IMPL_VER(IMPL_VER)) u_store (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (bus_wr),
        .dec         (dec),
        .wdata       (bus_wdata),
        .flt_valid   (flt_valid),
        .flt_is_read (flt_is_read),
        .flt_page    (flt_page),
        .rd_word     (bus_rdata),
        .tbl_base    (tbl_base),
        .win_start   (win_start),
        .xlat_en     (xlat_en)
    );

    assign touch_fault = (bus_rd || bus_wr) &&
                         (dec.sel == SEL_FSTAT || dec.sel == SEL_FADDR);

    ioxc_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .set_evt (flt_valid),
        .clr_evt (touch_fault),
        .irq     (irq)
    );

    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (dec.sel == SEL_NONE) |-> (bus_rdata == 32'h0));
endmodule

// File: tb/ioxlat_csr_bench.sv
module ioxlat_csr_bench;
    localparam int          CLK_PERIOD = 10;
    localparam logic [7:0]  VER        = 8'h5A;
    localparam logic [31:0] VW         = {VER, 24'h0};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [13:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        flt_valid = 1'b0, flt_is_read = 1'b0;
    logic [31:0] flt_page = '0;
    logic        irq, xlat_en;
    logic [31:0] tbl_base, win_start;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ioxlat_csr #(.IMPL_VER(VER)) u_ioxlat_csr (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .flt_valid(flt_valid), .flt_is_read(flt_is_read), .flt_page(flt_page),
        .irq(irq), .tbl_base(tbl_base), .win_start(win_start), .xlat_en(xlat_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compares read data in the middle of the read cycle
    always @(negedge clk) begin
        if (bus_rd) begin
            item_t it;
            if (sb_q.size() == 0) begin
                chk("scoreboard underflow", 32'h1, 32'h0);
            end else begin
                it = sb_q.pop_front();
                chk(it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic wr(input logic [13:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [13:0] a, input logic [31:0] exp, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_rd = 1'b1; bus_addr = a;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic capture(input logic is_rd, input logic [31:0] page);
        @(posedge clk); #1;
        flt_valid = 1'b1; flt_is_read = is_rd; flt_page = page;
        @(posedge clk); #1;
        flt_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 win_start", win_start, 32'h0);
        chk("R1 xlat_en", {31'h0, xlat_en}, 32'h0);
        chk("R1 tbl_base", tbl_base, 32'h0);
        rd(14'h0000, VW,           "R1 control");
        rd(14'h2000, 32'h00000008, "R1 arbitration enable");
        rd(14'h1000, 32'h00800000, "R1 fault status");
        rd(14'h1008, 32'h00000003, "R1 arbiter enable");
        rd(14'h3018, 32'h23000000, "R1 mask id");
        rd(14'h0004, 32'h0,        "R1 base");
        rd(14'h1004, 32'h0,        "R1 fault address");
        rd(14'h1014, 32'h0,        "R1 slot1");

        // R2 control mask and version
        wr(14'h0000, 32'hFFFF_FFFF);
        rd(14'h0000, VW | 32'h1D, "R2 control all ones");
        chk("R2 xlat_en set", {31'h0, xlat_en}, 32'h1);
        chk("R3 window 2GB", win_start, 32'h8000_0000);
        wr(14'h0000, 32'h0000_0000);
        chk("R2 xlat_en clear", {31'h0, xlat_en}, 32'h0);

        // R3 every range value
        for (int n = 0; n < 8; n++) begin
            wr(14'h0000, 32'(n) << 2);
            chk("R3 window start", win_start, 32'hFFFF_FFFF << (24 + n));
            rd(14'h0000, VW | (32'(n) << 2), "R2 control range readback");
        end
        wr(14'h0004, 32'h0000_1234);
        chk("R3 window unchanged by other write", win_start, 32'h8000_0000);

        // R4 base and flush
        wr(14'h0004, 32'hFFFF_FFFF);
        rd(14'h0004, 32'h07FF_FC00, "R4 base mask");
        chk("R4 tbl_base export", tbl_base, 32'h07FF_FC00);
        wr(14'h0014, 32'hDEAD_BEEF);
        rd(14'h0014, 32'hDEAD_BEEF, "R4 tlb flush");
        wr(14'h0018, 32'h1357_9BDF);
        rd(14'h0018, 32'h1357_9BDF, "R4 page flush");

        // R5 arbiter enable
        wr(14'h1008, 32'h0);
        rd(14'h1008, 32'h1, "R5 arbiter zero write");
        wr(14'h1008, 32'hFFFF_FFFF);
        rd(14'h1008, 32'h801F_000F, "R5 arbiter ones write");

        // R6 fault registers
        wr(14'h1000, 32'h0);
        rd(14'h1000, 32'h0080_0000, "R6 fault status zero write");
        wr(14'h1000, 32'hFFFF_FFFF);
        rd(14'h1000, 32'hFF8F_FFFF, "R6 fault status ones write");
        wr(14'h1004, 32'hA5A5_5A5A);
        rd(14'h1004, 32'hA5A5_5A5A, "R6 fault address");

        // R7 slot and arbitration enable
        for (int s = 0; s < 4; s++) begin
            wr(14'h1010 + 14'(4*s), 32'hFFFF_FFFF);
            rd(14'h1010 + 14'(4*s), 32'h0001_0003, "R7 slot config");
        end
        wr(14'h2000, 32'hFFFF_FFFF);
        rd(14'h2000, 32'h001F_0008, "R7 arbitration ones");
        wr(14'h2000, 32'h0);
        rd(14'h2000, 32'h0000_0008, "R7 arbitration zero");

        // R8 mask id accumulate
        wr(14'h3018, 32'h0000_0011);
        rd(14'h3018, 32'h2300_0011, "R8 mask id first");
        wr(14'h3018, 32'hFF00_0022);
        rd(14'h3018, 32'h2300_0033, "R8 mask id accumulate");
        wr(14'h3018, 32'h0);
        rd(14'h3018, 32'h2300_0033, "R8 mask id no clear");

        // R11 unmapped and misaligned
        wr(14'h0008, 32'hFFFF_FFFF);
        rd(14'h0008, 32'h0, "R11 unmapped read");
        wr(14'h0005, 32'h0);
        rd(14'h0005, 32'h0, "R11 misaligned read");
        rd(14'h0004, 32'h07FF_FC00, "R11 misaligned write ignored");
        chk("R11 irq untouched", {31'h0, irq}, 32'h0);

        // R9 / R10 capture and clear by read
        capture(1'b1, 32'h1234_5000);
        chk("R9 irq raised", {31'h0, irq}, 32'h1);
        rd(14'h0000, VW | 32'h1C, "R10 control read");
        chk("R10 irq held on other read", {31'h0, irq}, 32'h1);
        rd(14'h1000, 32'hC086_0000, "R9 status read fault");
        chk("R10 irq lowered by status read", {31'h0, irq}, 32'h0);
        rd(14'h1004, 32'h1234_5000, "R9 fault address");

        capture(1'b0, 32'h0ABC_D000);
        rd(14'h1000, 32'hC082_0000, "R9 status write fault");
        capture(1'b0, 32'h0ABC_E000);
        chk("R9 irq raised again", {31'h0, irq}, 32'h1);
        wr(14'h1004, 32'h0);
        chk("R10 irq lowered by address write", {31'h0, irq}, 32'h0);

        // R9 priority over a same-cycle bus write
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = 14'h1000; bus_wdata = 32'h0;
        flt_valid = 1'b1; flt_is_read = 1'b0; flt_page = 32'h7777_7000;
        @(posedge clk); #1;
        bus_wr = 1'b0; flt_valid = 1'b0;
        chk("R9 irq wins over clear", {31'h0, irq}, 32'h1);
        rd(14'h1000, 32'hC082_0000, "R9 capture wins status");
        rd(14'h1004, 32'h7777_7000, "R9 capture address");
        capture(1'b1, 32'h0000_1000);
        wr(14'h1000, 32'h0);
        chk("R10 irq lowered by status write", {31'h0, irq}, 32'h0);

        repeat (2) @(posedge clk);
        chk("scoreboard drained", 32'(sb_q.size()), 32'h0);
        finish_run();
    end
endmodule